// File: doc/BRIEF.md
# Delayed One-Shot Buffer DMA Engine

This block moves a run of bytes between a 4096-byte on-chip buffer and an external byte-addressed memory. Software programs a source address, a destination address, a byte count and a command word through a small register port. Setting the command's run bit arms a start timer. When the timer expires, the engine checks that the buffer-side range lies inside the local buffer window, which sits at device addresses 0x40000 to 0x40FFF. If the range is valid, it moves one byte per memory handshake until the count is used up.

The direction bit decides which address is the buffer-side address and which is the external-side address. The external-side address is cut to 28 bits before use. While a transfer is armed or moving, software cannot change the four DMA registers. Software either polls the run bit until it drops or waits for the completion pulse and the optional interrupt cause. A range that fails the check aborts the transfer with no data movement and sets a sticky error flag.

Top module: `tdma_engine`

## Requirements
- R1: Register offsets are source 0x80, destination 0x88, count 0x90 and command 0x98, each 64 bits wide and reset to zero. An 8-byte write stores all 64 bits. A 4-byte write stores data bits 31:0 with the upper half cleared. An 8-byte read returns the whole register, and a 4-byte read returns bits 31:0 with the upper half zero.
- R2: An access whose size is neither 4 nor 8 is ignored if it is a write and reads as all ones. A read at any offset other than the four above also returns all ones.
- R3: A command write with data bit 0 (run) equal to 0 is ignored entirely.
- R4: While run reads as 1, writes to all four registers are ignored, but reads still return their contents.
- R5: Command bit 1 selects the direction. With 0, source is external and destination is the buffer address (external into buffer). With 1, source is the buffer address and destination is external (buffer out to external). Command bit 2 enables the completion interrupt.
- R6: The range decision happens DELAY_CYCLES clock edges after the edge that accepted the run command. For an accepted range, mem_req is first high in the cycle after that decision edge.
- R7: The range is accepted only if the buffer-side address lies in [0x40000, 0x41000), the count is non-zero, and address plus count does not exceed 0x41000; a range ending exactly at 0x41000 is accepted. A rejected range clears run at the decision edge, issues no request, gives no done pulse and no interrupt, and sets err_flag, which stays 1 until reset.
- R8: mem_addr starts at the external-side register value ANDed with 2^28−1 and rises by one per byte. The buffer byte index starts at the buffer-side address minus 0x40000.
- R9: One byte moves per handshake, that is, per cycle with mem_req and mem_gnt both high. mem_req, mem_we, mem_addr and mem_wdata stay stable until granted. mem_we equals command bit 1. When reading, mem_rdata is taken in the grant cycle.
- R10: The clock edge of the last handshake clears run. done is then high for exactly one cycle. In that same cycle irq_vec is 0x00000100 if command bit 2 is set; otherwise irq_vec stays 0.
- R11: Bytes loaded from external memory into the buffer are written back out unchanged by a later buffer-to-external transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational from the access inputs |
| mem_req | output | 1 | External byte request |
| mem_we | output | 1 | 1 = write to external memory |
| mem_addr | output | EXT_AW (28) | External byte address |
| mem_wdata | output | 8 | Byte written to external memory |
| mem_gnt | input | 1 | Accepts the current request this cycle |
| mem_rdata | input | 8 | Read byte, valid in the grant cycle |
| done | output | 1 | One-cycle completion pulse |
| irq_vec | output | 32 | Interrupt cause, 0x00000100 for one cycle when enabled |
| err_flag | output | 1 | Sticky range-rejection flag |

## Verification
The assertions assume that the memory side keeps mem_rdata valid during every grant cycle and that mem_gnt is never relied on outside a request. They also assume that reset is applied before any register access. The stimulus drives accesses only between clock edges, asserts mem_gnt from a pseudo-random sequence so that requests are held for varied stretches, and performs buffer-to-external transfers only over buffer bytes that an earlier transfer has filled. Register writes during a running transfer and run-less command writes are issued on purpose to exercise the locking and ignore rules.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_MOVE = 2'd2
  } sq_state_e;

  localparam logic [7:0] OFS_SRC = 8'h80;
  localparam logic [7:0] OFS_DST = 8'h88;
  localparam logic [7:0] OFS_CNT = 8'h90;
  localparam logic [7:0] OFS_CMD = 8'h98;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IRQ = 2;

  localparam logic [31:0] DMA_IRQ_CAUSE = 32'h0000_0100;

  // Register access widths accepted by the port.
  function automatic logic access_ok(input logic [3:0] size);
    return (size == 4'd4) || (size == 4'd8);
  endfunction

  // Buffer-side span check: start inside window, non-empty, end not past window.
  function automatic logic span_ok(input logic [63:0] start, input logic [63:0] len,
                                   input logic [63:0] base, input logic [63:0] bytes);
    logic [64:0] stop;
    logic [64:0] lim;
    stop = {1'b0, start} + {1'b0, len};
    lim  = {1'b0, base} + {1'b0, bytes};
    return (start >= base) && ({1'b0, start} < lim) && (len != 64'd0) && (stop <= lim);
  endfunction

endpackage

// File: rtl/tdma_buffer.sv
module tdma_buffer #(
  parameter int unsigned BYTES = 4096
) (
  input  logic                       clk,
  input  logic                       we_i,
  input  logic [$clog2(BYTES)-1:0]   off_i,
  input  logic [7:0]                 wbyte_i,
  output logic [7:0]                 rbyte_o
);
  localparam int OFF_W = $clog2(BYTES);
  localparam int WORDS = BYTES / 4;
  localparam int LANES = 4;

  logic [7:0] lane_rd [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_q [WORDS];
    logic       lane_sel;
    assign lane_sel = (off_i[1:0] == 2'(l));
    always_ff @(posedge clk) begin
      if (we_i && lane_sel) lane_q[off_i[OFF_W-1:2]] <= wbyte_i;
    end
    assign lane_rd[l] = lane_q[off_i[OFF_W-1:2]];
  end

  assign rbyte_o = lane_rd[off_i[1:0]];
endmodule

// File: rtl/tdma_regs.sv
module tdma_regs
  import tdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  input  logic        fin_i,
  output logic [63:0] src_o,
  output logic [63:0] dst_o,
  output logic [63:0] cnt_o,
  output logic        run_o,
  output logic        dir_o,
  output logic        irq_en_o,
  output logic        go_o
);
  logic [63:0] src_q, dst_q, cnt_q, cmd_q;
  logic [63:0] wval, rsel;
  logic        size_good, wr_ok, rd_hit;

  assign size_good = access_ok(reg_size);
  assign wr_ok     = reg_en && reg_we && size_good && !cmd_q[CMD_RUN];
  assign wval      = (reg_size == 4'd4) ? {32'h0, reg_wdata[31:0]} : reg_wdata;
  assign go_o      = wr_ok && (reg_addr == OFS_CMD) && wval[CMD_RUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      cmd_q <= '0;
    end else begin
      if (wr_ok && reg_addr == OFS_SRC) src_q <= wval;
      if (wr_ok && reg_addr == OFS_DST) dst_q <= wval;
      if (wr_ok && reg_addr == OFS_CNT) cnt_q <= wval;
      if (go_o) cmd_q <= wval;
      else if (fin_i) cmd_q[CMD_RUN] <= 1'b0;
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    rsel   = '1;
    case (reg_addr)
      OFS_SRC: rsel = src_q;
      OFS_DST: rsel = dst_q;
      OFS_CNT: rsel = cnt_q;
      OFS_CMD: rsel = cmd_q;
      default: rd_hit = 1'b0;
    endcase
    if (!(reg_en && !reg_we && size_good && rd_hit)) reg_rdata = '1;
    else if (reg_size == 4'd4) reg_rdata = {32'h0, rsel[31:0]};
    else reg_rdata = rsel;
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign cnt_o    = cnt_q;
  assign run_o    = cmd_q[CMD_RUN];
  assign dir_o    = cmd_q[CMD_DIR];
  assign irq_en_o = cmd_q[CMD_IRQ];

  // R4: register writes while running leave the programmed values alone.
  p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[CMD_RUN] && reg_en && reg_we) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));

  // R3: a run-less command write while idle changes nothing.
  p_norun_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_q[CMD_RUN] && reg_en && reg_we && reg_addr == OFS_CMD && !reg_wdata[CMD_RUN])
      |=> $stable(cmd_q));
endmodule

// File: rtl/tdma_sequencer.sv
module tdma_sequencer
  import tdma_pkg::*;
#(
  parameter logic [63:0] BUF_BASE     = 64'h40000,
  parameter int unsigned BUF_BYTES    = 4096,
  parameter int unsigned EXT_AW       = 28,
  parameter int unsigned DELAY_CYCLES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go_i,
  input  logic [63:0]                   src_i,
  input  logic [63:0]                   dst_i,
  input  logic [63:0]                   cnt_i,
  input  logic                          dir_i,
  input  logic                          irq_en_i,
  output logic                          fin_o,
  output logic                          done_o,
  output logic [31:0]                   irq_vec_o,
  output logic                          err_o,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [EXT_AW-1:0]             mem_addr,
  input  logic                          mem_gnt,
  output logic [$clog2(BUF_BYTES)-1:0]  buf_off_o,
  output logic                          buf_we_o
);
  localparam int OFF_W = $clog2(BUF_BYTES);
  localparam int CNT_W = OFF_W + 1;
  localparam int TMR_W = $clog2(DELAY_CYCLES + 1);

  function automatic logic [EXT_AW-1:0] ext_clip(input logic [63:0] a);
    return a[EXT_AW-1:0];
  endfunction

  function automatic logic [OFF_W-1:0] buf_index(input logic [63:0] a);
    logic [63:0] d;
    d = a - BUF_BASE;
    return d[OFF_W-1:0];
  endfunction

  sq_state_e         state_q;
  logic [TMR_W-1:0]  timer_q;
  logic [CNT_W-1:0]  left_q;
  logic [EXT_AW-1:0] ext_q;
  logic [OFF_W-1:0]  off_q;
  logic              done_q, irq_q, err_q;

  logic [63:0] buf_side, ext_side;
  logic        span_good, decide_ev, accept_ev, reject_ev, beat_ev, last_ev;

  assign buf_side  = dir_i ? src_i : dst_i;
  assign ext_side  = dir_i ? dst_i : src_i;
  assign span_good = span_ok(buf_side, cnt_i, BUF_BASE, 64'(BUF_BYTES));
  assign decide_ev = (state_q == SQ_WAIT) && (timer_q == '0);
  assign accept_ev = decide_ev && span_good;
  assign reject_ev = decide_ev && !span_good;
  assign beat_ev   = (state_q == SQ_MOVE) && mem_gnt;
  assign last_ev   = beat_ev && (left_q == CNT_W'(1));
  assign fin_o     = reject_ev || last_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      timer_q <= '0;
      left_q  <= '0;
      ext_q   <= '0;
      off_q   <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= last_ev;
      irq_q  <= last_ev && irq_en_i;
      if (reject_ev) err_q <= 1'b1;
      case (state_q)
        SQ_IDLE: begin
          if (go_i) begin
            state_q <= SQ_WAIT;
            timer_q <= TMR_W'(DELAY_CYCLES - 1);
          end
        end
        SQ_WAIT: begin
          if (accept_ev) begin
            state_q <= SQ_MOVE;
            left_q  <= cnt_i[CNT_W-1:0];
            ext_q   <= ext_clip(ext_side);
            off_q   <= buf_index(buf_side);
          end else if (reject_ev) begin
            state_q <= SQ_IDLE;
          end else begin
            timer_q <= timer_q - TMR_W'(1);
          end
        end
        SQ_MOVE: begin
          if (beat_ev) begin
            ext_q  <= ext_q + EXT_AW'(1);
            off_q  <= off_q + OFF_W'(1);
            left_q <= left_q - CNT_W'(1);
            if (last_ev) state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign mem_req   = (state_q == SQ_MOVE);
  assign mem_we    = dir_i;
  assign mem_addr  = ext_q;
  assign buf_off_o = off_q;
  assign buf_we_o  = beat_ev && !dir_i;
  assign done_o    = done_q;
  assign irq_vec_o = irq_q ? DMA_IRQ_CAUSE : 32'h0;
  assign err_o     = err_q;

  // R9: an ungranted request holds its address and direction.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7: the error flag never drops without reset.
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R7: a rejected span issues no request afterwards.
  p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (!mem_req && !done_o));

  // R10: the interrupt cause only appears alongside completion.
  p_irq_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec_o != 32'h0) |-> done_o);
endmodule

// File: rtl/tdma_engine.sv
module tdma_engine
  import tdma_pkg::*;
#(
  parameter logic [63:0] BUF_BASE     = 64'h40000,
  parameter int unsigned BUF_BYTES    = 4096,
  parameter int unsigned EXT_AW       = 28,
  parameter int unsigned DELAY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [EXT_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [31:0]       irq_vec,
  output logic              err_flag
);
  localparam int OFF_W = $clog2(BUF_BYTES);

  logic [63:0]      src_w, dst_w, cnt_w;
  logic             run_w, dir_w, irq_en_w, go_w, fin_w, buf_we_w;
  logic [OFF_W-1:0] buf_off_w;

  tdma_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_size  (reg_size),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .fin_i     (fin_w),
    .src_o     (src_w),
    .dst_o     (dst_w),
    .cnt_o     (cnt_w),
    .run_o     (run_w),
    .dir_o     (dir_w),
    .irq_en_o  (irq_en_w),
    .go_o      (go_w)
  );

  tdma_sequencer #(
    .BUF_BASE     (BUF_BASE),
    .BUF_BYTES    (BUF_BYTES),
    .EXT_AW       (EXT_AW),
    .DELAY_CYCLES (DELAY_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_w),
    .src_i     (src_w),
    .dst_i     (dst_w),
    .cnt_i     (cnt_w),
    .dir_i     (dir_w),
    .irq_en_i  (irq_en_w),
    .fin_o     (fin_w),
    .done_o    (done),
    .irq_vec_o (irq_vec),
    .err_o     (err_flag),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_gnt   (mem_gnt),
    .buf_off_o (buf_off_w),
    .buf_we_o  (buf_we_w)
  );

  tdma_buffer #(.BYTES(BUF_BYTES)) u_buf (
    .clk     (clk),
    .we_i    (buf_we_w),
    .off_i   (buf_off_w),
    .wbyte_i (mem_rdata),
    .rbyte_o (mem_wdata)
  );

  // R10: completion is only reported once run has dropped.
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !run_w);

  // R6: the engine never requests memory while run is clear.
  p_req_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> run_w);
endmodule

// File: tb/tdma_engine_tb.sv
module tdma_engine_tb_top;
  localparam int TB_DELAY = 8;
  localparam longint unsigned WBASE = 64'h40000;
  localparam longint unsigned WSIZE = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        r_en = 1'b0, r_we = 1'b0;
  logic [7:0]  r_addr = 8'h0;
  logic [3:0]  r_size = 4'd8;
  logic [63:0] r_wdata = '0;
  logic [63:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt = 1'b0;
  logic [27:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        done, err_flag;
  logic [31:0] irq_vec;

  logic [7:0] ext_mem [0:8191];
  assign mem_rdata = ext_mem[mem_addr[12:0]];

  int n_chk = 0, n_fail = 0, n_done = 0, n_irq = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tdma_engine #(.DELAY_CYCLES(TB_DELAY)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(r_en), .reg_we(r_we), .reg_addr(r_addr),
    .reg_size(r_size), .reg_wdata(r_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .done(done), .irq_vec(irq_vec),
    .err_flag(err_flag)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic note(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [63:0] m_src, m_dst, m_cnt, m_cmd;
  int          m_phase, m_left, m_off;
  longint      m_cyc, m_start;
  logic [27:0] m_ext;
  bit          m_done, m_irq, m_err;
  logic [7:0]  m_buf [0:4095];
  longint unsigned t_ba, t_ea;
  logic [63:0] t_wv;
  bit          t_fin, t_lock;

  function automatic logic [63:0] exp_rd();
    logic [63:0] v;
    if (!(r_en && !r_we && (r_size == 4 || r_size == 8))) return '1;
    case (r_addr)
      8'h80: v = m_src;
      8'h88: v = m_dst;
      8'h90: v = m_cnt;
      8'h98: v = m_cmd;
      default: return '1;
    endcase
    return (r_size == 4) ? {32'h0, v[31:0]} : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_cnt = 0; m_cmd = 0; m_phase = 0; m_left = 0; m_off = 0;
      m_cyc = 0; m_start = 0; m_ext = 0; m_done = 0; m_irq = 0; m_err = 0;
    end else begin
      m_cyc++;
      t_fin = 0; t_lock = m_cmd[0]; m_done = 0; m_irq = 0;
      if (m_phase == 1 && m_cyc == m_start + TB_DELAY) begin
        t_ba = m_cmd[1] ? m_src : m_dst;
        t_ea = m_cmd[1] ? m_dst : m_src;
        if (t_ba >= WBASE && t_ba < WBASE + WSIZE && m_cnt != 0 &&
            m_cnt <= WBASE + WSIZE - t_ba) begin
          m_phase = 2; m_left = int'(m_cnt); m_ext = 28'(t_ea & 64'h0FFF_FFFF);
          m_off = int'(t_ba - WBASE);
        end else begin
          m_phase = 0; m_err = 1; t_fin = 1;
        end
      end else if (m_phase == 2 && mem_gnt) begin
        if (!m_cmd[1]) m_buf[m_off] = ext_mem[m_ext[12:0]];
        m_ext++; m_off++; m_left--;
        if (m_left == 0) begin
          m_phase = 0; t_fin = 1; m_done = 1; m_irq = m_cmd[2];
        end
      end
      if (r_en && r_we && (r_size == 4 || r_size == 8) && !t_lock) begin
        t_wv = (r_size == 4) ? {32'h0, r_wdata[31:0]} : r_wdata;
        case (r_addr)
          8'h80: m_src = t_wv;
          8'h88: m_dst = t_wv;
          8'h90: m_cnt = t_wv;
          8'h98: if (t_wv[0]) begin m_cmd = t_wv; m_phase = 1; m_start = m_cyc; end
          default: ;
        endcase
      end
      if (t_fin) m_cmd[0] = 1'b0;
    end
  end

  // environment memory and grant pattern
  always @(posedge clk)
    if (rst_n && mem_req && mem_gnt && mem_we) ext_mem[mem_addr[12:0]] <= mem_wdata;

  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_gnt = lfsr[1] | lfsr[4];
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      note("R6", "mem_req", 64'(mem_req), 64'(m_phase == 2));
      if (m_phase == 2) begin
        note("R9", "mem_we", 64'(mem_we), 64'(m_cmd[1]));
        note("R8", "mem_addr", 64'(mem_addr), 64'(m_ext));
        if (m_cmd[1]) note("R11", "mem_wdata", 64'(mem_wdata), 64'(m_buf[m_off]));
      end
      note("R10", "done", 64'(done), 64'(m_done));
      note("R10", "irq_vec", 64'(irq_vec), m_irq ? 64'h100 : 64'h0);
      note("R7", "err_flag", 64'(err_flag), 64'(m_err));
      note("R1", "reg_rdata", reg_rdata, exp_rd());
    end
  end

  always @(negedge clk) begin
    #3;
    if (rst_n && done) n_done++;
    if (rst_n && irq_vec == 32'h100) n_irq++;
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    r_en = 1; r_we = 1; r_addr = a; r_size = sz; r_wdata = d;
    @(negedge clk);
    r_en = 0; r_we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [3:0] sz,
                        input logic [63:0] exp);
    @(negedge clk);
    r_en = 1; r_we = 0; r_addr = a; r_size = sz;
    #2 note(req, "read", reg_rdata, exp);
  endtask

  task automatic wait_idle(input string req);
    int k;
    k = 0;
    do begin
      @(negedge clk);
      r_en = 1; r_we = 0; r_addr = 8'h98; r_size = 4'd8;
      #2 k++;
    end while (reg_rdata[0] && k < 2000);
    note(req, "run cleared", 64'(reg_rdata[0]), 64'h0);
    @(negedge clk);
    r_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic setup(input logic [63:0] s, input logic [63:0] d, input logic [63:0] c);
    wr(8'h80, 4'd8, s);
    wr(8'h88, 4'd8, d);
    wr(8'h90, 4'd8, c);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) ext_mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // reset state (R1, R7, R10)
    note("R1", "reset done", 64'(done), 0);
    note("R7", "reset err", 64'(err_flag), 0);
    note("R9", "reset req", 64'(mem_req), 0);
    rd_chk("R1", 8'h80, 4'd8, 64'h0);
    rd_chk("R1", 8'h98, 4'd8, 64'h0);

    // R1 register widths
    wr(8'h80, 4'd8, 64'h1122_3344_5566_7788);
    rd_chk("R1", 8'h80, 4'd8, 64'h1122_3344_5566_7788);
    rd_chk("R1", 8'h80, 4'd4, 64'h5566_7788);
    wr(8'h88, 4'd4, 64'hDEAD_BEEF_0004_0010);
    rd_chk("R1", 8'h88, 4'd8, 64'h0004_0010);
    // R2 illegal sizes and offsets
    wr(8'h88, 4'd2, 64'h1234);
    rd_chk("R2", 8'h88, 4'd8, 64'h0004_0010);
    rd_chk("R2", 8'h88, 4'd1, '1);
    rd_chk("R2", 8'h84, 4'd4, '1);
    // R3 run-less command
    wr(8'h98, 4'd8, 64'h6);
    rd_chk("R3", 8'h98, 4'd8, 64'h0);

    // Transfer A: external into buffer with interrupt, masked source (R5, R6, R8)
    setup(64'hF000_0100, 64'h40010, 64'd20);
    wr(8'h98, 4'd8, 64'h5);
    begin
      int k;
      k = 1;
      #2;
      while (!mem_req && k < 100) begin @(negedge clk); #2 k++; end
      note("R6", "start delay", 64'(k), 64'(TB_DELAY + 1));
      note("R8", "masked first address", 64'(mem_addr), 64'h100);
      note("R5", "dir ext->buf", 64'(mem_we), 64'h0);
    end
    wait_idle("R10");
    note("R10", "done pulses A", 64'(n_done), 1);
    note("R10", "irq pulses A", 64'(n_irq), 1);

    // Transfer B: buffer out to external, no interrupt, writes while locked (R4, R11)
    setup(64'h40010, 64'h1000, 64'd20);
    wr(8'h98, 4'd8, 64'h3);
    wr(8'h80, 4'd8, 64'h777);
    wr(8'h98, 4'd8, 64'h5);
    rd_chk("R4", 8'h80, 4'd8, 64'h40010);
    rd_chk("R4", 8'h98, 4'd8, 64'h3);
    wait_idle("R10");
    for (int i = 0; i < 20; i++)
      note("R11", "round trip byte", 64'(ext_mem[13'h1000 + 13'(i)]), 64'(pat(16'h100 + i)));
    note("R10", "done pulses B", 64'(n_done), 2);
    note("R10", "no irq without enable", 64'(n_irq), 1);

    // Boundary: span ending exactly at the window end (R7)
    setup(64'h200, 64'h40FFC, 64'd4);
    wr(8'h98, 4'd8, 64'h1);
    wait_idle("R7");
    setup(64'h40FFC, 64'h1800, 64'd4);
    wr(8'h98, 4'd8, 64'h3);
    wait_idle("R7");
    for (int i = 0; i < 4; i++)
      note("R7", "edge span byte", 64'(ext_mem[13'h1800 + 13'(i)]), 64'(pat(16'h200 + i)));
    note("R7", "edge span no error", 64'(err_flag), 0);

    // Reject: past the window end
    setup(64'h0, 64'h40FFE, 64'd4);
    wr(8'h98, 4'd8, 64'h5);
    wait_idle("R7");
    note("R7", "err after overrun", 64'(err_flag), 1);
    note("R7", "no done on reject", 64'(n_done), 4);
    note("R7", "no irq on reject", 64'(n_irq), 1);

    // Reject: zero count
    do_reset();
    #2 note("R7", "err cleared by reset", 64'(err_flag), 0);
    setup(64'h0, 64'h40000, 64'd0);
    wr(8'h98, 4'd8, 64'h1);
    wait_idle("R7");
    note("R7", "err after zero count", 64'(err_flag), 1);

    // Reject: buffer-side source below the window
    do_reset();
    setup(64'h3FFFF, 64'h0, 64'd2);
    wr(8'h98, 4'd8, 64'h3);
    wait_idle("R5");
    note("R5", "err on low source", 64'(err_flag), 1);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule